// File: doc/BRIEF.md
# Single DMA Channel with Audio Refill Mode

This block is one channel of a memory-to-memory transfer engine. Software programs a source address, a destination address, a transfer count and a control word through a small write port. When the channel is enabled it copies working versions of the address and count registers. It then moves data one element at a time over a simple master port: a read from the working source, followed by a write of the returned data to the working destination. After each element both working addresses are adjusted according to their own modes.

A two-bit start field chooses what starts a run. The run can start as soon as the enable bit is written, on a vertical-blank pulse, on a horizontal-blank pulse, or on a refill request from one of two audio FIFOs. The audio mode always moves four 32-bit words into a fixed destination, and it responds only when the programmed destination equals the address of the FIFO that made the request. A repeating channel goes idle after every run and waits for its next trigger, which reloads the count.

The sequencer has four states. `ST_IDLE` waits for the channel to be active. It goes to `ST_READ` for a legal source mode, or to `ST_FAULT` when the source mode is illegal. `ST_READ` holds the read request until it is granted, then goes to `ST_WRITE`. `ST_WRITE` holds the write request until it is granted; that grant completes the step, and the state returns to `ST_IDLE`. `ST_FAULT` lasts one cycle, reports the error, disables the channel and returns to `ST_IDLE`.

Top module: `dmach_top`

## Requirements
- R1: After reset `bus_valid_o` and `err_o` are low, and no transfer happens until the channel is programmed. Configuration select values: 0 source, 1 destination, 2 count, 3 control. Control bits: [1:0] destination mode, [3:2] source mode, [4] repeat, [5] 32-bit size, [7:6] start, [8] enable.
- R2: When the control word changes enable from 0 to 1, the working source, destination and count are loaded from the programmed values. With start 00 the run begins at once.
- R3: Each step is a read of the working source (`bus_write_o`=0), followed by a write (`bus_write_o`=1) to the working destination. The write data is the read data, and only the low 16 bits are meaningful in 16-bit mode. A request stays valid and stable until `bus_ready_i` grants it. Exactly one step is taken per granted write.
- R4: A step moves the address by 4 in 32-bit mode and by 2 in 16-bit mode. Source mode 00 increments, 01 decrements and 10 holds the address.
- R5: Destination mode 00 and mode 11 both increment, 01 decrements and 10 holds the address.
- R6: A programmed count of zero gives 2^CNT_W-1 steps.
- R7: Start 01 begins a run on a `vblank_i` pulse and start 10 on an `hblank_i` pulse. Other triggers do nothing.
- R8: When the count reaches zero the channel goes idle, even if repeat is set. If repeat is clear, enable also clears, so later triggers are ignored.
- R9: When a blanking trigger starts a repeating channel, the count reloads from the programmed value. The working destination reloads only in destination mode 11; otherwise it continues from where it stopped.
- R10: A blanking trigger that arrives while a run is in progress is ignored, so the run length is unchanged.
- R11: With start 11 and enable set, a request on `snd_req_a_i` or `snd_req_b_i` starts a run only if the programmed destination equals FIFO_A_ADDR or FIFO_B_ADDR respectively. That run is four steps long, and it sets the repeat bit so that later requests are served.
- R12: In the audio mode every transfer is 32-bit, whatever the size bit says, and the destination address never changes.
- R13: Source mode 11 is illegal. Starting a run with it raises `err_o` for exactly one cycle, issues no bus request and disables the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select (0 src, 1 dst, 2 count, 3 control) |
| cfg_wdata | input | ADDR_W | Configuration write data |
| vblank_i | input | 1 | Vertical-blank trigger pulse |
| hblank_i | input | 1 | Horizontal-blank trigger pulse |
| snd_req_a_i | input | 1 | Refill request from audio FIFO A |
| snd_req_b_i | input | 1 | Refill request from audio FIFO B |
| bus_valid_o | output | 1 | Bus request valid |
| bus_write_o | output | 1 | 1 = write, 0 = read |
| bus_word_o | output | 1 | 1 = 32-bit, 0 = 16-bit |
| bus_addr_o | output | ADDR_W | Request address |
| bus_wdata_o | output | 32 | Write data |
| bus_ready_i | input | 1 | Grant of the current request |
| bus_rdata_i | input | 32 | Read data, valid with a granted read |
| err_o | output | 1 | One-cycle illegal-source-mode pulse |

## Verification
The bench builds the channel with CNT_W=4, which makes the zero-count case a run of only 15 steps so the whole maximum-length run is checked element by element. The two FIFO addresses are set to 0xF00 and 0xF04; matching and non-matching destinations, and requests from the wrong FIFO, can then all be produced from ordinary test addresses. The bus slave withholds the grant on every third request, so the hold-until-granted rule and the trigger-during-run case are both exercised.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

    typedef enum logic [1:0] {
        ADJ_INC     = 2'b00,
        ADJ_DEC     = 2'b01,
        ADJ_FIX     = 2'b10,
        ADJ_INC_RLD = 2'b11
    } adj_e;

    typedef enum logic [1:0] {
        TRG_NOW = 2'b00,
        TRG_VBL = 2'b01,
        TRG_HBL = 2'b10,
        TRG_SND = 2'b11
    } trig_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_FAULT
    } seq_state_e;

    typedef struct packed {
        logic  en;
        trig_e start;
        logic  word;
        logic  rep;
        adj_e  sadj;
        adj_e  dadj;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [1:0] SEL_SRC  = 2'd0;
    localparam logic [1:0] SEL_DST  = 2'd1;
    localparam logic [1:0] SEL_CNT  = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

    localparam int SND_BURST = 4;

endpackage

// File: rtl/dmach_addr_next.sv
module dmach_addr_next
    import dmach_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter bit IS_DST = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    input  adj_e              adj,
    input  logic              word,
    output logic [ADDR_W-1:0] nxt
);
    localparam logic [ADDR_W-1:0] STEP_W = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] STEP_H = ADDR_W'(2);

    logic [ADDR_W-1:0] delta;
    assign delta = word ? STEP_W : STEP_H;

    generate
        if (IS_DST) begin : g_dst
            always_comb begin
                unique case (adj)
                    ADJ_INC, ADJ_INC_RLD: nxt = addr + delta;
                    ADJ_DEC:              nxt = addr - delta;
                    default:              nxt = addr;
                endcase
            end
        end else begin : g_src
            // mode 11 is illegal for the source; the sequencer faults before any step
            always_comb begin
                unique case (adj)
                    ADJ_INC: nxt = addr + delta;
                    ADJ_DEC: nxt = addr - delta;
                    default: nxt = addr;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/dmach_ctx.sv
module dmach_ctx
    import dmach_pkg::*;
#(
    parameter int              ADDR_W      = 32,
    parameter int              CNT_W       = 14,
    parameter bit              SPECIAL_OK  = 1'b1,
    parameter logic [ADDR_W-1:0] FIFO_A_ADDR = 32'h0000_0F00,
    parameter logic [ADDR_W-1:0] FIFO_B_ADDR = 32'h0000_0F04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              vblank_i,
    input  logic              hblank_i,
    input  logic              snd_req_a_i,
    input  logic              snd_req_b_i,
    input  logic              step_fire,
    input  logic              abort,
    input  logic [ADDR_W-1:0] src_nxt,
    input  logic [ADDR_W-1:0] dst_nxt,
    output ctrl_t             ctrl,
    output logic [ADDR_W-1:0] w_src,
    output logic [ADDR_W-1:0] w_dst,
    output logic              active,
    output logic              special
);
    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_BURST = CNT_W'(SND_BURST);

    logic [ADDR_W-1:0] p_src, p_dst;
    logic [CNT_W-1:0]  p_cnt, w_cnt, load_cnt;
    ctrl_t             new_ctrl;
    logic              trig_blank, trig_snd;

    assign load_cnt = (p_cnt == '0) ? '1 : p_cnt;
    assign new_ctrl = ctrl_t'(cfg_wdata[CTRL_W-1:0]);
    assign special  = SPECIAL_OK && (ctrl.start == TRG_SND);

    assign trig_blank = ((ctrl.start == TRG_VBL) && vblank_i) ||
                        ((ctrl.start == TRG_HBL) && hblank_i);
    assign trig_snd   = special &&
                        ((snd_req_a_i && (p_dst == FIFO_A_ADDR)) ||
                         (snd_req_b_i && (p_dst == FIFO_B_ADDR)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_src  <= '0;
            p_dst  <= '0;
            p_cnt  <= '0;
            ctrl   <= '0;
            w_src  <= '0;
            w_dst  <= '0;
            w_cnt  <= '0;
            active <= 1'b0;
        end else begin
            if (step_fire) begin
                w_src <= src_nxt;
                if (!special) w_dst <= dst_nxt;
                w_cnt <= w_cnt - CNT_ONE;
                if (w_cnt == CNT_ONE) begin
                    active <= 1'b0;
                    if (!ctrl.rep) ctrl.en <= 1'b0;
                end
            end
            if (!active && ctrl.en && trig_blank) begin
                active <= 1'b1;
                if (ctrl.rep) begin
                    w_cnt <= load_cnt;
                    if (ctrl.dadj == ADJ_INC_RLD) w_dst <= p_dst;
                end
            end
            if (!active && ctrl.en && trig_snd) begin
                active   <= 1'b1;
                w_cnt    <= CNT_BURST;
                ctrl.rep <= 1'b1;
            end
            if (cfg_we) begin
                unique case (cfg_sel)
                    SEL_SRC: p_src <= cfg_wdata;
                    SEL_DST: p_dst <= cfg_wdata;
                    SEL_CNT: p_cnt <= cfg_wdata[CNT_W-1:0];
                    default: begin
                        ctrl <= new_ctrl;
                        if (new_ctrl.en && !ctrl.en) begin
                            w_src  <= p_src;
                            w_dst  <= p_dst;
                            w_cnt  <= load_cnt;
                            active <= (new_ctrl.start == TRG_NOW);
                        end else if (!new_ctrl.en) begin
                            active <= 1'b0;
                        end
                    end
                endcase
            end
            if (abort) begin
                active  <= 1'b0;
                ctrl.en <= 1'b0;
            end
        end
    end

    // R10: while a run is in progress only a completed step moves the count
    p_run_count_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        active && !step_fire |=> $stable(w_cnt));

    // R8: the last step leaves the channel idle
    p_last_step_idles_r8: assert property (@(posedge clk) disable iff (!rst_n)
        step_fire && (w_cnt == CNT_ONE) && !cfg_we && !abort |=> !active);

endmodule

// File: rtl/dmach_seq.sv
module dmach_seq
    import dmach_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              src_illegal,
    input  logic              word,
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] dst,
    input  logic              bus_ready_i,
    input  logic [31:0]       bus_rdata_i,
    output logic              bus_valid_o,
    output logic              bus_write_o,
    output logic              bus_word_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [31:0]       bus_wdata_o,
    output logic              step_fire,
    output logic              abort
);
    seq_state_e state, state_nxt;
    logic [31:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                data_q <= '0;
        else if ((state == ST_READ) && bus_ready_i) data_q <= bus_rdata_i;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (active) state_nxt = src_illegal ? ST_FAULT : ST_READ;
            ST_READ:  if (bus_ready_i) state_nxt = ST_WRITE;
            ST_WRITE: if (bus_ready_i) state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        bus_valid_o = 1'b0;
        bus_write_o = 1'b0;
        bus_addr_o  = src;
        bus_wdata_o = data_q;
        bus_word_o  = word;
        step_fire   = 1'b0;
        abort       = 1'b0;
        unique case (state)
            ST_READ:  bus_valid_o = 1'b1;
            ST_WRITE: begin
                bus_valid_o = 1'b1;
                bus_write_o = 1'b1;
                bus_addr_o  = dst;
                step_fire   = bus_ready_i;
            end
            ST_FAULT: abort = 1'b1;
            default:  ;
        endcase
    end

    // R3: an ungranted request keeps its kind and address
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid_o && !bus_ready_i |=> bus_valid_o && $stable(bus_write_o) && $stable(bus_addr_o));

    // R3: a granted read is followed by its write
    p_read_then_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid_o && bus_ready_i && !bus_write_o |=> bus_valid_o && bus_write_o);

    // R13: the fault indication is a single-cycle pulse
    p_fault_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !abort);

endmodule

// File: rtl/dmach_top.sv
module dmach_top
    import dmach_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                CNT_W       = 14,
    parameter bit                SPECIAL_OK  = 1'b1,
    parameter logic [ADDR_W-1:0] FIFO_A_ADDR = 32'h0000_0F00,
    parameter logic [ADDR_W-1:0] FIFO_B_ADDR = 32'h0000_0F04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              vblank_i,
    input  logic              hblank_i,
    input  logic              snd_req_a_i,
    input  logic              snd_req_b_i,
    output logic              bus_valid_o,
    output logic              bus_write_o,
    output logic              bus_word_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [31:0]       bus_wdata_o,
    input  logic              bus_ready_i,
    input  logic [31:0]       bus_rdata_i,
    output logic              err_o
);
    ctrl_t             ctrl;
    logic [ADDR_W-1:0] w_src, w_dst, src_nxt, dst_nxt;
    logic              active, special, step_fire, abort, eff_word;

    assign eff_word = ctrl.word || special;
    assign err_o    = abort;

    dmach_ctx #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SPECIAL_OK(SPECIAL_OK),
        .FIFO_A_ADDR(FIFO_A_ADDR), .FIFO_B_ADDR(FIFO_B_ADDR)
    ) u_ctx (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .vblank_i(vblank_i), .hblank_i(hblank_i),
        .snd_req_a_i(snd_req_a_i), .snd_req_b_i(snd_req_b_i),
        .step_fire(step_fire), .abort(abort),
        .src_nxt(src_nxt), .dst_nxt(dst_nxt),
        .ctrl(ctrl), .w_src(w_src), .w_dst(w_dst),
        .active(active), .special(special)
    );

    dmach_addr_next #(.ADDR_W(ADDR_W), .IS_DST(1'b0)) u_src_next (
        .addr(w_src), .adj(ctrl.sadj), .word(eff_word), .nxt(src_nxt)
    );

    dmach_addr_next #(.ADDR_W(ADDR_W), .IS_DST(1'b1)) u_dst_next (
        .addr(w_dst), .adj(ctrl.dadj), .word(eff_word), .nxt(dst_nxt)
    );

    dmach_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .active(active), .src_illegal(ctrl.sadj == ADJ_INC_RLD),
        .word(eff_word), .src(w_src), .dst(w_dst),
        .bus_ready_i(bus_ready_i), .bus_rdata_i(bus_rdata_i),
        .bus_valid_o(bus_valid_o), .bus_write_o(bus_write_o),
        .bus_word_o(bus_word_o), .bus_addr_o(bus_addr_o),
        .bus_wdata_o(bus_wdata_o),
        .step_fire(step_fire), .abort(abort)
    );

    // R12: audio refill runs always request 32-bit transfers
    p_audio_word_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid_o && special |-> bus_word_o);

    // R13: a fault cycle never carries a bus request
    p_fault_no_bus_r13: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !bus_valid_o);

endmodule

// File: tb/tb_dmach_top.sv
module tb_dmach_top;
    localparam logic [31:0] FA = 32'h0000_0F00;
    localparam logic [31:0] FB = 32'h0000_0F04;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic vblank_i = 1'b0, hblank_i = 1'b0, snd_req_a_i = 1'b0, snd_req_b_i = 1'b0;
    logic bus_valid_o, bus_write_o, bus_word_o, err_o;
    logic [31:0] bus_addr_o, bus_wdata_o;
    logic bus_ready_i = 1'b0;
    logic [31:0] bus_rdata_i = '0;

    always #5 clk = ~clk;

    dmach_top #(.ADDR_W(32), .CNT_W(4), .SPECIAL_OK(1'b1),
                .FIFO_A_ADDR(FA), .FIFO_B_ADDR(FB)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .vblank_i(vblank_i), .hblank_i(hblank_i),
        .snd_req_a_i(snd_req_a_i), .snd_req_b_i(snd_req_b_i),
        .bus_valid_o(bus_valid_o), .bus_write_o(bus_write_o),
        .bus_word_o(bus_word_o), .bus_addr_o(bus_addr_o),
        .bus_wdata_o(bus_wdata_o), .bus_ready_i(bus_ready_i),
        .bus_rdata_i(bus_rdata_i), .err_o(err_o)
    );

    int n_cmp = 0, n_bad = 0, n_wr = 0, n_err = 0, stall = 0;
    string cur_req = "R1";
    logic [65:0] exp_q[$];   // {write, word, addr, data}
    logic [31:0] m_src, m_dst;

    function automatic logic [31:0] pat(logic [31:0] a);
        return {a[15:0] ^ 16'h3C5A, ~a[15:0]};
    endfunction

    function automatic logic [31:0] ctl(bit en, bit [1:0] st, bit wd, bit rp, bit [1:0] sa, bit [1:0] da);
        return {23'b0, en, st, wd, rp, sa, da};
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // bus slave and per-clock comparison against the model queue
    initial begin
        forever begin
            @(negedge clk);
            bus_ready_i = 1'b0;
            if (err_o) n_err++;
            if (bus_valid_o) begin
                stall++;
                if ((stall % 3) != 2) begin
                    bus_ready_i = 1'b1;
                    bus_rdata_i = pat(bus_addr_o);
                    if (bus_write_o) n_wr++;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, cur_req, {31'b0, bus_write_o, bus_addr_o}, 64'h0);
                    end else begin
                        logic [65:0] e;
                        logic [31:0] mask;
                        e = exp_q.pop_front();
                        mask = e[64] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
                        chk(bus_write_o == e[65] && bus_word_o == e[64] && bus_addr_o == e[63:32] &&
                            (!e[65] || ((bus_wdata_o & mask) == (e[31:0] & mask))),
                            cur_req,
                            {bus_write_o, bus_word_o, bus_addr_o[29:0], bus_wdata_o},
                            {e[65], e[64], e[61:32], e[31:0]});
                    end
                end
            end
        end
    end

    task automatic cfg(logic [1:0] sel, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(int which);
        @(negedge clk);
        case (which)
            0: vblank_i = 1'b1;
            1: hblank_i = 1'b1;
            2: snd_req_a_i = 1'b1;
            default: snd_req_b_i = 1'b1;
        endcase
        @(negedge clk);
        vblank_i = 1'b0; hblank_i = 1'b0; snd_req_a_i = 1'b0; snd_req_b_i = 1'b0;
    endtask

    task automatic arm(logic [31:0] s, logic [31:0] d, logic [31:0] c);
        cfg(2'd3, 32'h0);
        cfg(2'd0, s);
        cfg(2'd1, d);
        cfg(2'd2, c);
        m_src = s; m_dst = d;
    endtask

    task automatic exp_burst(int n, bit wd, bit [1:0] sa, bit [1:0] da, bit fixdst);
        logic [31:0] dl;
        dl = wd ? 32'd4 : 32'd2;
        for (int i = 0; i < n; i++) begin
            exp_q.push_back({1'b0, wd, m_src, pat(m_src)});
            exp_q.push_back({1'b1, wd, m_dst, pat(m_src)});
            if (sa == 2'b00) m_src = m_src + dl;
            else if (sa == 2'b01) m_src = m_src - dl;
            if (!fixdst) begin
                if (da == 2'b00 || da == 2'b11) m_dst = m_dst + dl;
                else if (da == 2'b01) m_dst = m_dst - dl;
            end
        end
    endtask

    task automatic drain();
        for (int g = 0; g < 3000 && exp_q.size() != 0; g++) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, cur_req, 64'(exp_q.size()), 64'h0);
    endtask

    task automatic quiet(string tag, int cycles);
        int w0;
        w0 = n_wr;
        repeat (cycles) @(negedge clk);
        chk(n_wr == w0, tag, 64'(n_wr - w0), 64'h0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        int w0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        chk(bus_valid_o == 1'b0, "R1", 64'(bus_valid_o), 64'h0);
        chk(err_o == 1'b0, "R1", 64'(err_o), 64'h0);
        quiet("R1", 6);

        // R2 R3 R4: immediate start, 32-bit, both increment
        cur_req = "R2";
        arm(32'h100, 32'h800, 32'd3);
        exp_burst(3, 1, 2'b00, 2'b00, 0);
        cfg(2'd3, ctl(1, 2'b00, 1, 0, 2'b00, 2'b00));
        drain();

        // R4 R5: 16-bit, source decrement, destination fixed
        cur_req = "R4";
        arm(32'h200, 32'h900, 32'd2);
        exp_burst(2, 0, 2'b01, 2'b10, 0);
        cfg(2'd3, ctl(1, 2'b00, 0, 0, 2'b01, 2'b10));
        drain();

        // R5: source fixed, destination decrement, 32-bit
        cur_req = "R5";
        arm(32'h240, 32'h980, 32'd2);
        exp_burst(2, 1, 2'b10, 2'b01, 0);
        cfg(2'd3, ctl(1, 2'b00, 1, 0, 2'b10, 2'b01));
        drain();

        // R6: zero count gives 15 steps with CNT_W=4
        cur_req = "R6";
        arm(32'h400, 32'hB00, 32'd0);
        exp_burst(15, 1, 2'b00, 2'b00, 0);
        cfg(2'd3, ctl(1, 2'b00, 1, 0, 2'b00, 2'b00));
        drain();

        // R7 R9 R8: vblank start, repeat, destination reload mode
        cur_req = "R7";
        arm(32'h300, 32'hA00, 32'd2);
        cfg(2'd3, ctl(1, 2'b01, 0, 1, 2'b00, 2'b11));
        quiet("R7", 6);
        pulse(1);
        quiet("R7", 6);
        exp_burst(2, 0, 2'b00, 2'b11, 0);
        pulse(0);
        drain();
        cur_req = "R9";
        m_dst = 32'hA00;
        exp_burst(2, 0, 2'b00, 2'b11, 0);
        pulse(0);
        drain();
        quiet("R8", 8);

        // R9: destination increment mode continues without reload
        cur_req = "R9";
        arm(32'h340, 32'hA80, 32'd2);
        cfg(2'd3, ctl(1, 2'b01, 1, 1, 2'b00, 2'b00));
        exp_burst(2, 1, 2'b00, 2'b00, 0);
        pulse(0);
        drain();
        exp_burst(2, 1, 2'b00, 2'b00, 0);
        pulse(0);
        drain();

        // R10: hblank during a run is ignored
        cur_req = "R10";
        arm(32'h500, 32'hC00, 32'd3);
        cfg(2'd3, ctl(1, 2'b10, 1, 1, 2'b00, 2'b00));
        exp_burst(3, 1, 2'b00, 2'b00, 0);
        pulse(1);
        repeat (2) @(negedge clk);
        pulse(1);
        drain();
        exp_burst(3, 1, 2'b00, 2'b00, 0);
        pulse(1);
        drain();

        // R8: without repeat, a later trigger does nothing
        cur_req = "R8";
        arm(32'h540, 32'hC80, 32'd2);
        cfg(2'd3, ctl(1, 2'b10, 1, 0, 2'b00, 2'b00));
        exp_burst(2, 1, 2'b00, 2'b00, 0);
        pulse(1);
        drain();
        pulse(1);
        quiet("R8", 10);

        // R11 R12: audio refill, size bit clear, destination mode increment
        cur_req = "R11";
        arm(32'h600, FA, 32'd7);
        cfg(2'd3, ctl(1, 2'b11, 0, 0, 2'b00, 2'b00));
        pulse(3);
        quiet("R11", 8);
        pulse(0);
        quiet("R11", 8);
        cur_req = "R12";
        exp_burst(4, 1, 2'b00, 2'b00, 1);
        pulse(2);
        drain();
        cur_req = "R11";
        exp_burst(4, 1, 2'b00, 2'b00, 1);
        pulse(2);
        drain();

        // R11: destination matching neither FIFO never starts
        cur_req = "R11";
        arm(32'h680, 32'h700, 32'd3);
        cfg(2'd3, ctl(1, 2'b11, 1, 0, 2'b00, 2'b00));
        pulse(2);
        pulse(3);
        quiet("R11", 10);

        // R13: illegal source mode
        cur_req = "R13";
        arm(32'h780, 32'hD00, 32'd2);
        w0 = n_err;
        cfg(2'd3, ctl(1, 2'b00, 1, 0, 2'b11, 2'b00));
        quiet("R13", 10);
        chk(n_err - w0 == 1, "R13", 64'(n_err - w0), 64'h1);

        summary();
    end

endmodule